// File: doc/BRIEF.md
# Oversampled serial receiver with idle-line flag

This block turns an asynchronous serial line into data words and keeps a small set of status flags for a host. A strobe at sixteen times the bit rate, made elsewhere, times all sampling. A falling edge on the line while the receiver is hunting starts a frame. Each bit, the start bit included, is sampled three times around its middle, and the majority value is taken. A mode input picks eight or nine data bits, and the data arrive least significant bit first.

The finished word moves into a data register. The moment of that move is the middle of the stop bit. The flags cover a full data register, overrun, noise, framing error and idle line. An interrupt request is formed from the flags and two enable inputs. The host clears the flags in two steps: it pulses a status read, then it pulses a data read.

The frame state machine has four states. ST_HUNT waits for a high-to-low step of the sampled line. ST_START qualifies the start bit. ST_DATA collects the data bits. ST_STOP samples the stop bit. The transitions are as follows:
- hunt→start, on an edge while the receiver is enabled.
- start→hunt, a false start, when the start majority is high.
- start→data, when the start majority is low.
- data→stop, after the last data bit.
- stop→hunt, once the stop bit has been sampled.
- any state→hunt, when the receiver is disabled.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, all five flags, `irq` and `rx_data` are 0.
- R2: In 8-bit mode (`word9`=0), a frame has one low start bit, then 8 data bits LSB first, then a stop bit. After the frame, `rx_data[7:0]` holds the byte, `rx_data[8]` is 0, and `flag_full` is 1.
- R3: In 9-bit mode (`word9`=1), the frame carries 9 data bits, and the ninth bit received appears on `rx_data[8]`.
- R4: Each bit is sampled on oversample ticks 7, 8 and 9 of its 16, counting the start edge tick as tick 0. The bit value is the majority of the three samples. If the three samples disagree in any bit of a frame, `flag_noise` sets for that frame, and the data are still correct.
- R5: If the start-bit majority is high, the receiver returns to hunting. No word is delivered.
- R6: A stop bit whose majority is low sets `flag_frame`, and the word is still delivered. After such a frame, the receiver waits for the line to go high again before it hunts for a new start edge.
- R7: A frame that completes while `flag_full` is 1 sets `flag_overrun`. That frame is discarded, so `rx_data` keeps the old word and `flag_noise`/`flag_frame` are unchanged.
- R8: A `rd_status` pulse followed by a `rd_data` pulse clears all five flags. A `rd_data` pulse with no `rd_status` pulse before it clears nothing.
- R9: After a frame with a good stop bit, `flag_idle` sets once the line has been high while hunting for one frame time of ticks: 160 ticks in 8-bit mode and 176 ticks in 9-bit mode. The flag cannot set before such a frame has been received, and it does not set a second time until another good frame arrives.
- R10: `irq` = (`rx_irq_en` & (`flag_full` | `flag_overrun`)) | (`idle_irq_en` & `flag_idle`).
- R11: While `rx_enable` is 0, `rx_data` reads 0 and frames on the line are ignored, so `flag_full` does not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| rx_enable | input | 1 | Receiver enable |
| word9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rx_irq_en | input | 1 | Interrupt enable for data full and overrun |
| idle_irq_en | input | 1 | Interrupt enable for idle line |
| rd_status | input | 1 | One-cycle status read strobe |
| rd_data | input | 1 | One-cycle data read strobe |
| rx_data | output | 9 | Last received word (0 while disabled) |
| flag_full | output | 1 | Data register holds an unread word |
| flag_overrun | output | 1 | A word was lost |
| flag_noise | output | 1 | Sample disagreement in the held word |
| flag_frame | output | 1 | Stop bit of the held word was low |
| flag_idle | output | 1 | Line idle for a frame time after a good word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest conditions to reach are a single bad sample inside a bit and the idle threshold. A single bad sample must flip exactly one of the three mid-bit votes, and the idle threshold is counted from the middle of the stop bit. The bench drives both the oversample strobe and the line, one line value per tick. This lets it invert exactly tick 8 of a chosen bit and place idle-time probes a known number of ticks after a frame. It uses both a probe that falls short of the threshold and one that passes it.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic [8:0] data;
        logic       noise;
        logic       ferr;
    } rx_frame_t;
endpackage

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import serial_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DBITS = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      line_s,
    input  logic      enable,
    input  logic      word9,
    output logic      hunting,
    output logic      frame_done,
    output rx_frame_t frame
);
    localparam int CW  = $clog2(OSR);
    localparam int BW  = $clog2(DBITS + 2);
    localparam int MID = OSR / 2;
    localparam logic [CW-1:0] SA   = CW'(MID - 1);
    localparam logic [CW-1:0] SB   = CW'(MID);
    localparam logic [CW-1:0] SC   = CW'(MID + 1);
    localparam logic [CW-1:0] CTOP = CW'(OSR - 1);

    rx_state_t       state, state_n;
    logic [CW-1:0]   cnt;
    logic [BW-1:0]   bitn;
    logic [DBITS:0]  shreg;
    logic [1:0]      votes;
    logic            noisy;
    logic            prev_line;
    logic            at_mid, maj, dis;
    logic [BW-1:0]   last_bit;

    assign at_mid   = tick && (cnt == SC);
    assign maj      = (votes[0] & votes[1]) | (votes[0] & line_s) | (votes[1] & line_s);
    assign dis      = (votes[0] != votes[1]) || (votes[1] != line_s);
    assign last_bit = word9 ? BW'(DBITS) : BW'(DBITS - 1);
    assign hunting  = (state == ST_HUNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_HUNT:  if (tick && prev_line && !line_s) state_n = ST_START;
            ST_START: if (at_mid) state_n = maj ? ST_HUNT : ST_DATA;
            ST_DATA:  if (at_mid && bitn == last_bit) state_n = ST_STOP;
            ST_STOP:  if (at_mid) state_n = ST_HUNT;
        endcase
        if (!enable) state_n = ST_HUNT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            bitn       <= '0;
            shreg      <= '0;
            votes      <= '0;
            noisy      <= 1'b0;
            prev_line  <= 1'b1;
            frame_done <= 1'b0;
            frame      <= '0;
        end else begin
            frame_done <= 1'b0;
            if (tick) begin
                prev_line <= line_s;
                if (state == ST_HUNT)  cnt <= CW'(1);
                else if (cnt == CTOP)  cnt <= '0;
                else                   cnt <= cnt + 1'b1;
                if (cnt == SA) votes[0] <= line_s;
                if (cnt == SB) votes[1] <= line_s;
            end
            if (at_mid && enable) begin
                unique case (state)
                    ST_START: begin
                        bitn  <= '0;
                        shreg <= '0;
                        noisy <= dis;
                    end
                    ST_DATA: begin
                        shreg[bitn] <= maj;
                        bitn        <= bitn + 1'b1;
                        noisy       <= noisy | dis;
                    end
                    ST_STOP: begin
                        frame_done  <= 1'b1;
                        frame.data  <= 9'(shreg);
                        frame.noise <= noisy | dis;
                        frame.ferr  <= ~maj;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(state) == ST_STOP);                       // R2
    AST_STOP_BITCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP) |-> (bitn == last_bit + 1'b1));             // R3
    AST_DISABLE_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state == ST_HUNT);                                 // R11
    AST_START_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_START) |-> $past(!line_s));                  // R5
endmodule

// File: rtl/rx_idle_watch.sv
module rx_idle_watch #(
    parameter int LIMW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            line_s,
    input  logic            enable,
    input  logic            hunting,
    input  logic            char_ok,
    input  logic [LIMW-1:0] limit,
    output logic            idle_set
);
    logic [LIMW-1:0] run;
    logic            armed;
    logic            quiet;

    assign quiet = line_s && hunting && enable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run      <= '0;
            armed    <= 1'b0;
            idle_set <= 1'b0;
        end else begin
            idle_set <= 1'b0;
            if (char_ok) armed <= 1'b1;
            if (tick) begin
                if (!quiet)            run <= '0;
                else if (run != limit) run <= run + 1'b1;
                if (armed && quiet && run == limit - 1'b1) begin
                    idle_set <= 1'b1;
                    armed    <= 1'b0;
                end
            end
        end
    end

    AST_IDLE_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        idle_set |-> $past(line_s));                                   // R9
endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags
    import serial_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      frame_done,
    input  rx_frame_t frame,
    input  logic      idle_set,
    input  logic      rd_status,
    input  logic      rd_data,
    input  logic      rx_irq_en,
    input  logic      idle_irq_en,
    output logic [8:0] rx_data,
    output logic      flag_full,
    output logic      flag_overrun,
    output logic      flag_noise,
    output logic      flag_frame,
    output logic      flag_idle,
    output logic      irq
);
    logic [8:0] data_r;
    logic       stat_seen;
    logic       clr;
    logic       full_n, ovr_n, nse_n, fe_n, idl_n;

    assign clr = rd_data && stat_seen;

    always_comb begin
        full_n = clr ? 1'b0 : flag_full;
        ovr_n  = clr ? 1'b0 : flag_overrun;
        nse_n  = clr ? 1'b0 : flag_noise;
        fe_n   = clr ? 1'b0 : flag_frame;
        idl_n  = clr ? 1'b0 : flag_idle;
        if (frame_done) begin
            if (full_n) begin
                ovr_n = 1'b1;
            end else begin
                full_n = 1'b1;
                nse_n  = frame.noise;
                fe_n   = frame.ferr;
            end
        end
        if (idle_set) idl_n = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_r       <= '0;
            stat_seen    <= 1'b0;
            flag_full    <= 1'b0;
            flag_overrun <= 1'b0;
            flag_noise   <= 1'b0;
            flag_frame   <= 1'b0;
            flag_idle    <= 1'b0;
        end else begin
            if (rd_status)    stat_seen <= 1'b1;
            else if (rd_data) stat_seen <= 1'b0;
            if (frame_done && !(clr ? 1'b0 : flag_full)) data_r <= frame.data;
            flag_full    <= full_n;
            flag_overrun <= ovr_n;
            flag_noise   <= nse_n;
            flag_frame   <= fe_n;
            flag_idle    <= idl_n;
        end
    end

    assign rx_data = enable ? data_r : 9'd0;
    assign irq     = (rx_irq_en & (flag_full | flag_overrun)) | (idle_irq_en & flag_idle);

    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && flag_full && !clr) |=> $stable(data_r));        // R7
    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_overrun) |-> flag_full);                            // R7
    AST_LONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !stat_seen && flag_full) |=> flag_full);           // R8
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DBITS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rx_in,
    input  logic       rx_enable,
    input  logic       word9,
    input  logic       rx_irq_en,
    input  logic       idle_irq_en,
    input  logic       rd_status,
    input  logic       rd_data,
    output logic [8:0] rx_data,
    output logic       flag_full,
    output logic       flag_overrun,
    output logic       flag_noise,
    output logic       flag_frame,
    output logic       flag_idle,
    output logic       irq
);
    localparam int LIMMAX = OSR * (DBITS + 3);
    localparam int LIMW   = $clog2(LIMMAX + 1);

    logic [1:0]      sync;
    logic            line_s;
    logic            hunting, frame_done, idle_set, char_ok;
    rx_frame_t       frame;
    logic [LIMW-1:0] limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rx_in};
    end
    assign line_s  = sync[1];
    assign limit   = word9 ? LIMW'(OSR * (DBITS + 3)) : LIMW'(OSR * (DBITS + 2));
    assign char_ok = frame_done && !frame.ferr;

    rx_frame_fsm #(.OSR(OSR), .DBITS(DBITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .line_s(line_s),
        .enable(rx_enable), .word9(word9), .hunting(hunting),
        .frame_done(frame_done), .frame(frame)
    );

    rx_idle_watch #(.LIMW(LIMW)) u_idle (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .line_s(line_s),
        .enable(rx_enable), .hunting(hunting), .char_ok(char_ok),
        .limit(limit), .idle_set(idle_set)
    );

    rx_status_flags u_flags (
        .clk(clk), .rst_n(rst_n), .enable(rx_enable), .frame_done(frame_done),
        .frame(frame), .idle_set(idle_set), .rd_status(rd_status),
        .rd_data(rd_data), .rx_irq_en(rx_irq_en), .idle_irq_en(idle_irq_en),
        .rx_data(rx_data), .flag_full(flag_full), .flag_overrun(flag_overrun),
        .flag_noise(flag_noise), .flag_frame(flag_frame), .flag_idle(flag_idle),
        .irq(irq)
    );

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_full | flag_overrun | flag_idle));               // R10
endmodule

// File: tb/serial_rx_core_bench.sv
`timescale 1ns/1ps
module serial_rx_core_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b0, rx_in = 1'b1, rx_enable = 1'b1, word9 = 1'b0;
    logic rx_irq_en = 1'b0, idle_irq_en = 1'b0, rd_status = 1'b0, rd_data = 1'b0;
    logic [8:0] rx_data;
    logic flag_full, flag_overrun, flag_noise, flag_frame, flag_idle, irq;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    serial_rx_core u_serial_rx_core (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
        .rx_enable(rx_enable), .word9(word9), .rx_irq_en(rx_irq_en),
        .idle_irq_en(idle_irq_en), .rd_status(rd_status), .rd_data(rd_data),
        .rx_data(rx_data), .flag_full(flag_full), .flag_overrun(flag_overrun),
        .flag_noise(flag_noise), .flag_frame(flag_frame), .flag_idle(flag_idle),
        .irq(irq)
    );

    function automatic logic exp_irq(logic rie, logic iie, logic f, logic o, logic i);
        return (rie & (f | o)) | (iie & i);
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic slot(logic v);
        rx_in = v;
        os_tick = 1'b0;
        repeat (3) @(negedge clk);
        os_tick = 1'b1;
        @(negedge clk);
        os_tick = 1'b0;
    endtask

    task automatic send_bit(logic v, bit glitch);
        for (int s = 0; s < 16; s++) slot((glitch && s == 8) ? ~v : v);
    endtask

    task automatic quiet(int n);
        for (int k = 0; k < n; k++) slot(1'b1);
    endtask

    task automatic send_frame(logic [8:0] d, bit nine, logic stop_v, int glitch_bit);
        send_bit(1'b0, glitch_bit == 0);
        for (int b = 0; b < (nine ? 9 : 8); b++) send_bit(d[b], glitch_bit == b + 1);
        send_bit(stop_v, 1'b0);
    endtask

    task automatic clear_flags();
        rd_status = 1'b1; @(negedge clk); rd_status = 1'b0;
        rd_data = 1'b1;   @(negedge clk); rd_data = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [8:0] d;
        bit nine, gl;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {flag_full, flag_overrun, flag_noise, flag_frame, flag_idle, irq}, 0);
        check("R1", rx_data, 0);

        // R9 no idle before any good frame
        quiet(300);
        check("R9", flag_idle, 0);

        // R2 directed 8-bit frame
        send_frame(9'h0A5, 0, 1'b1, -1);
        check("R2", rx_data, 9'h0A5);
        check("R2", flag_full, 1);
        check("R4", flag_noise, 0);
        // R10 interrupt from data full
        rx_irq_en = 1'b1; @(negedge clk);
        check("R10", irq, exp_irq(1, 0, 1, 0, 0));
        rx_irq_en = 1'b0; @(negedge clk);
        check("R10", irq, 0);
        // R8 lone data read keeps flags
        rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
        check("R8", flag_full, 1);
        clear_flags();
        check("R8", flag_full, 0);

        // R9 idle after good frame, threshold
        quiet(100);
        check("R9", flag_idle, 0);
        quiet(100);
        check("R9", flag_idle, 1);
        idle_irq_en = 1'b1; @(negedge clk);
        check("R10", irq, exp_irq(0, 1, 0, 0, 1));
        idle_irq_en = 1'b0;
        clear_flags();
        check("R8", flag_idle, 0);
        quiet(250);
        check("R9", flag_idle, 0);

        // R3 9-bit mode
        word9 = 1'b1;
        send_frame(9'h1C3, 1, 1'b1, -1);
        check("R3", rx_data, 9'h1C3);
        clear_flags();
        word9 = 1'b0;

        // R4 glitch in one sample
        send_frame(9'h03C, 0, 1'b1, 3);
        check("R4", rx_data, 9'h03C);
        check("R4", flag_noise, 1);
        clear_flags();
        check("R4", flag_noise, 0);

        // R5 false start
        for (int k = 0; k < 4; k++) slot(1'b0);
        quiet(40);
        check("R5", flag_full, 0);

        // R6 framing error
        send_frame(9'h05A, 0, 1'b0, -1);
        check("R6", flag_frame, 1);
        check("R6", rx_data, 9'h05A);
        quiet(20);
        check("R6", flag_full, 1);
        clear_flags();
        check("R6", flag_frame, 0);

        // R7 overrun keeps old data
        send_frame(9'h011, 0, 1'b1, -1);
        send_frame(9'h0EE, 0, 1'b1, 2);
        check("R7", flag_overrun, 1);
        check("R7", rx_data, 9'h011);
        check("R7", flag_noise, 0);
        rx_irq_en = 1'b1; @(negedge clk);
        check("R10", irq, 1);
        rx_irq_en = 1'b0;
        clear_flags();
        check("R7", flag_overrun, 0);

        // random frames
        for (int n = 0; n < 12; n++) begin
            nine = 1'($urandom_range(0, 1));
            d = 9'($urandom_range(0, 511));
            if (!nine) d[8] = 1'b0;
            gl = ($urandom_range(0, 3) == 0);
            word9 = nine;
            send_frame(d, nine, 1'b1, gl ? int'($urandom_range(0, 8)) : -1);
            check(nine ? "R3" : "R2", rx_data, d);
            check("R4", flag_noise, gl);
            clear_flags();
            quiet(int'($urandom_range(0, 5)));
        end
        word9 = 1'b0;
        quiet(20);

        // R11 disabled receiver
        rx_enable = 1'b0; @(negedge clk);
        check("R11", rx_data, 0);
        send_frame(9'h077, 0, 1'b1, -1);
        check("R11", flag_full, 0);
        rx_enable = 1'b1;
        quiet(10);
        send_frame(9'h066, 0, 1'b1, -1);
        check("R11", rx_data, 9'h066);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule